// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block holds the power-control special function register of an 8032-style core. It moves the core between three states: running, idle and power-down. The CPU writes the register through a simple SFR port. Setting the idle request bit gates the CPU clock while the oscillator keeps running. Setting the power-down request bit also drops the oscillator enable. Register contents are kept in both low-power states.

An enabled, pending interrupt ends idle. Hardware then clears the idle bit and the CPU clock comes back. Power-down ignores interrupts and ends only through reset.

Two reset requests feed a qualifier that counts raw input clocks. A machine cycle is 12 input clocks, and the counter keeps running while the CPU clock is gated.
- An external request must stay high for two whole machine cycles to be accepted. A shorter pulse leaves no trace.
- An internal request holds the core reset output for exactly three machine cycles.

Any accepted reset clears the register and returns the controller to the running state. The six remaining register bits drive side-band controls to neighbouring blocks: two UART rate doublers, a low-voltage-reset disable, an ADC interrupt enable, and two clock-select flags for the second UART.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the asynchronous reset, a read at address 0x87 returns 0x00 and all six control outputs are low. The CPU clock enable and the oscillator enable are high, and the core reset output is low. A read at any other address returns 0x00.
- R2: A write to 0x87 in the running state with bits 1:0 clear stores bits 7:2. The stored bits read back in place, and drive the outputs in this order from bit 7 down to bit 2: uart_dbl_o, uart2_dbl_o, lvr_dis_o, adc_ie_o, uart2_rclk_o, uart2_tclk_o.
- R3: A running-state write with bit 0 set and bit 1 clear enters idle from the next cycle. In idle, cpu_clk_en_o is low, osc_en_o stays high and the register reads bit 0 as 1.
- R4: In idle, a sampled irq_pend_i returns to the running state on the next cycle. Bit 0 is cleared and bits 7:2 are unchanged.
- R5: A running-state write with bit 1 set enters power-down from the next cycle, even when bit 0 is also set. In power-down, both enables are low and the register reads bit 1 as 1 and bit 0 as 0.
- R6: In power-down, irq_pend_i has no effect on the state, the enables or the register.
- R7: An external request counts only once ext_rst_i has been sampled high on 24 consecutive clock edges. On a shorter pulse, core_rst_o, the state and the register all stay unchanged.
- R8: Once an external request is accepted, core_rst_o rises after the 24th high edge. It falls on the cycle after ext_rst_i is sampled low.
- R9: An internal request sampled at one edge holds core_rst_o high for exactly 36 clock cycles, starting after that edge.
- R10: An accepted reset clears the register to 0x00 and returns the controller to the running state from idle or power-down. Writes are ignored while core_rst_o is high.
- R11: A write to 0x87 while in idle or power-down is ignored.
- R12: Writes to any address other than 0x87 leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw input clock, never gated |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_addr_i | input | 8 | SFR address |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | Register value when the address matches, else 0 |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| ext_rst_i | input | 1 | External reset request, level |
| int_rst_i | input | 1 | Internal reset request, sampled per edge |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| core_rst_o | output | 1 | Reset to the core |
| uart_dbl_o | output | 1 | UART baud-rate doubling |
| uart2_dbl_o | output | 1 | Second UART baud-rate doubling |
| lvr_dis_o | output | 1 | Low-voltage-reset disable |
| adc_ie_o | output | 1 | ADC interrupt enable |
| uart2_rclk_o | output | 1 | Second UART receive-clock select flag |
| uart2_tclk_o | output | 1 | Second UART transmit-clock select flag |

## Verification
The hardest situation to reach is the edge of external-reset qualification while the core is idle. There, a pulse one edge short must leave the register and the gated clock exactly as they were. A pulse of exactly the minimum width must clear both at a known cycle. The stimulus puts the core into idle with every upper bit set, then sweeps the pulse width from 1 to 30 edges. After every edge it compares core_rst_o with the width arithmetic. After release it checks whether the state was kept or wiped. Power-down is entered under the same scheme, and is left only by the external path or the internal three-machine-cycle hold.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_state_e;

  localparam int unsigned IDLE_BIT = 0;
  localparam int unsigned DOWN_BIT = 1;
  localparam int unsigned CTRL_W   = 6;
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int unsigned MC_LEN = 12,
  parameter int unsigned EXT_MC = 2,
  parameter int unsigned INT_MC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  input  logic int_rst_i,
  output logic accept_o,
  output logic core_rst_o
);
  localparam int unsigned EXT_LEN = MC_LEN * EXT_MC;
  localparam int unsigned INT_LEN = MC_LEN * INT_MC;
  localparam int unsigned EXT_W   = $clog2(EXT_LEN);
  localparam int unsigned HOLD_W  = $clog2(INT_LEN + 1);
  localparam logic [EXT_W-1:0]  EXT_LAST = EXT_W'(EXT_LEN - 1);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(INT_LEN);

  logic [EXT_W-1:0]  ext_cnt_q;
  logic              ext_act_q;
  logic [HOLD_W-1:0] hold_q;
  logic              ext_hit;

  assign ext_hit  = ext_rst_i && (ext_cnt_q == EXT_LAST) && !ext_act_q;
  assign accept_o = ext_hit || int_rst_i;

  // qualification counter runs on the raw clock, independent of the gate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_cnt_q <= '0;
      ext_act_q <= 1'b0;
    end else if (!ext_rst_i) begin
      ext_cnt_q <= '0;
      ext_act_q <= 1'b0;
    end else if (ext_cnt_q == EXT_LAST) begin
      ext_act_q <= 1'b1;
    end else begin
      ext_cnt_q <= ext_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hold_q <= '0;
    else if (int_rst_i)        hold_q <= HOLD_MAX;
    else if (hold_q != '0)     hold_q <= hold_q - 1'b1;
  end

  assign core_rst_o = ext_act_q || (hold_q != '0);

  a_r9_int_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_i |=> core_rst_o);
  a_r9_hold_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q <= HOLD_MAX);
  a_r7_ext_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_act_q) |-> $past(ext_rst_i));
  a_r8_ext_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_i |=> !ext_act_q);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      wr_i,
  input  logic      down_req_i,
  input  logic      idle_req_i,
  input  logic      irq_i,
  output pm_state_e state_o,
  output logic      wr_ok_o
);
  pm_state_e state_q, state_d;

  assign wr_ok_o = wr_i && (state_q == PM_RUN) && !clr_i;

  always_comb begin
    state_d = state_q;
    if (clr_i) begin
      state_d = PM_RUN;
    end else begin
      unique case (state_q)
        PM_RUN: begin
          if (wr_ok_o && down_req_i)      state_d = PM_DOWN;
          else if (wr_ok_o && idle_req_i) state_d = PM_IDLE;
        end
        PM_IDLE: if (irq_i) state_d = PM_RUN;
        PM_DOWN: state_d = PM_DOWN;
        default: state_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PM_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r6_down_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_DOWN && !clr_i) |=> state_q == PM_DOWN);
  a_r4_idle_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_IDLE && irq_i && !clr_i) |=> state_q == PM_RUN);
  a_r5_down_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok_o && down_req_i) |=> state_q == PM_DOWN);
  a_r10_clr_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> state_q == PM_RUN);
endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctrl_q <= '0;
    else if (clr_i) ctrl_q <= '0;
    else if (we_i)  ctrl_q <= wdata_i;
  end

  assign ctrl_o = ctrl_q;

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ctrl_q == '0);
  a_r11_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !clr_i) |=> $stable(ctrl_q));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter logic [7:0]  SFR_ADDR = 8'h87,
  parameter int unsigned MC_LEN   = 12,
  parameter int unsigned EXT_MC   = 2,
  parameter int unsigned INT_MC   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sfr_wr_i,
  input  logic [7:0] sfr_addr_i,
  input  logic [7:0] sfr_wdata_i,
  output logic [7:0] sfr_rdata_o,
  input  logic       irq_pend_i,
  input  logic       ext_rst_i,
  input  logic       int_rst_i,
  output logic       cpu_clk_en_o,
  output logic       osc_en_o,
  output logic       core_rst_o,
  output logic       uart_dbl_o,
  output logic       uart2_dbl_o,
  output logic       lvr_dis_o,
  output logic       adc_ie_o,
  output logic       uart2_rclk_o,
  output logic       uart2_tclk_o
);
  logic              hit;
  logic              accept;
  logic              core_rst;
  logic              clr;
  logic              wr_ok;
  pm_state_e         state;
  logic [CTRL_W-1:0] ctrl;
  logic [1:0]        mode_bits;

  assign hit = (sfr_addr_i == SFR_ADDR);

  pmc_rst_qual #(
    .MC_LEN(MC_LEN), .EXT_MC(EXT_MC), .INT_MC(INT_MC)
  ) i_rst_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_rst_i  (ext_rst_i),
    .int_rst_i  (int_rst_i),
    .accept_o   (accept),
    .core_rst_o (core_rst)
  );

  // clear on acceptance and for as long as the core is held
  assign clr = accept || core_rst;

  pmc_mode_fsm i_mode_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .wr_i       (sfr_wr_i && hit),
    .down_req_i (sfr_wdata_i[DOWN_BIT]),
    .idle_req_i (sfr_wdata_i[IDLE_BIT]),
    .irq_i      (irq_pend_i),
    .state_o    (state),
    .wr_ok_o    (wr_ok)
  );

  pmc_ctrl_reg i_ctrl_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .we_i    (wr_ok),
    .wdata_i (sfr_wdata_i[7:2]),
    .ctrl_o  (ctrl)
  );

  assign mode_bits[IDLE_BIT] = (state == PM_IDLE);
  assign mode_bits[DOWN_BIT] = (state == PM_DOWN);

  assign sfr_rdata_o  = hit ? {ctrl, mode_bits} : 8'h00;
  assign cpu_clk_en_o = (state == PM_RUN);
  assign osc_en_o     = (state != PM_DOWN);
  assign core_rst_o   = core_rst;

  assign uart_dbl_o   = ctrl[5];
  assign uart2_dbl_o  = ctrl[4];
  assign lvr_dis_o    = ctrl[3];
  assign adc_ie_o     = ctrl[2];
  assign uart2_rclk_o = ctrl[1];
  assign uart2_tclk_o = ctrl[0];

  a_r5_down_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !cpu_clk_en_o);
  a_r3_mode_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mode_bits));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h87;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq = 1'b0, ext = 1'b0, intr = 1'b0;
  logic       cpu_en, osc_en, crst;
  logic       o_ud, o_u2d, o_lvr, o_adc, o_rc, o_tc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sfr_wr_i(wr), .sfr_addr_i(addr),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata), .irq_pend_i(irq),
    .ext_rst_i(ext), .int_rst_i(intr), .cpu_clk_en_o(cpu_en),
    .osc_en_o(osc_en), .core_rst_o(crst), .uart_dbl_o(o_ud),
    .uart2_dbl_o(o_u2d), .lvr_dis_o(o_lvr), .adc_ie_o(o_adc),
    .uart2_rclk_o(o_rc), .uart2_tclk_o(o_tc)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0; addr = 8'h87;
  endtask

  task automatic rd(output logic [7:0] v);
    addr = 8'h87;
    #0.5;
    v = rdata;
  endtask

  logic [7:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=00 exp=01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(v); chk("R1 rdata", v, 8'h00);
    addr = 8'h86; #0.5; chk("R1 other addr", rdata, 8'h00); addr = 8'h87;
    chk("R1 enables", {6'd0, cpu_en, osc_en}, 8'h03);
    chk("R1 core_rst", {7'd0, crst}, 8'h00);
    chk("R1 ctrl", {2'd0, o_ud, o_u2d, o_lvr, o_adc, o_rc, o_tc}, 8'h00);

    // R2 / R12 sweep of upper bits
    for (int u = 0; u < 64; u++) begin
      sfr_wr(8'h87, 8'(u << 2));
      rd(v); chk("R2 readback", v, 8'(u << 2));
      chk("R2 outputs", {2'd0, o_ud, o_u2d, o_lvr, o_adc, o_rc, o_tc}, 8'(u));
      sfr_wr(8'h86, ~8'(u << 2));
      rd(v); chk("R12 other addr write", v, 8'(u << 2));
      chk("R2 run enables", {6'd0, cpu_en, osc_en}, 8'h03);
    end

    // R3 R4 R5 R6 R11 mode sweep
    for (int m = 1; m < 4; m++) begin
      for (int k = 0; k < 3; k++) begin
        logic [5:0] u;
        logic [7:0] mexp;
        u = (k == 0) ? 6'h15 : (k == 1) ? 6'h2A : 6'h3F;
        mexp = {u, (m >= 2) ? 2'b10 : 2'b01};
        sfr_wr(8'h87, {u, 2'(m)});
        rd(v); chk(m >= 2 ? "R5 mode read" : "R3 mode read", v, mexp);
        chk(m >= 2 ? "R5 enables" : "R3 enables", {6'd0, cpu_en, osc_en},
            (m >= 2) ? 8'h00 : 8'h01);
        sfr_wr(8'h87, 8'h00);
        rd(v); chk("R11 write in low power", v, mexp);
        irq = 1'b1; tick(); irq = 1'b0;
        rd(v);
        if (m == 1) begin
          chk("R4 wake read", v, {u, 2'b00});
          chk("R4 wake enables", {6'd0, cpu_en, osc_en}, 8'h03);
        end else begin
          chk("R6 irq ignored read", v, mexp);
          chk("R6 irq ignored enables", {6'd0, cpu_en, osc_en}, 8'h00);
          ext = 1'b1;
          repeat (24) tick();
          chk("R8 core_rst from down", {7'd0, crst}, 8'h01);
          rd(v); chk("R10 clear from down", v, 8'h00);
          chk("R10 run from down", {6'd0, cpu_en, osc_en}, 8'h03);
          ext = 1'b0; tick();
          chk("R8 release", {7'd0, crst}, 8'h00);
        end
      end
    end

    // R7 R8 R10 external width sweep from idle
    for (int w = 1; w <= 30; w++) begin
      sfr_wr(8'h87, 8'hFD);
      ext = 1'b1;
      for (int i = 1; i <= w; i++) begin
        tick();
        chk(i >= 24 ? "R8 core_rst width" : "R7 core_rst short",
            {7'd0, crst}, (i >= 24) ? 8'h01 : 8'h00);
      end
      ext = 1'b0; tick();
      chk("R8 core_rst after release", {7'd0, crst}, 8'h00);
      rd(v);
      if (w < 24) begin
        chk("R7 short pulse ignored read", v, 8'hFD);
        chk("R7 short pulse keeps idle", {6'd0, cpu_en, osc_en}, 8'h01);
        irq = 1'b1; tick(); irq = 1'b0;
      end else begin
        chk("R10 ext clear read", v, 8'h00);
        chk("R10 ext run", {6'd0, cpu_en, osc_en}, 8'h03);
      end
    end

    // R9 R10 internal reset from power-down
    sfr_wr(8'h87, 8'hAA);
    rd(v); chk("R5 down before int", v, 8'hAA);
    intr = 1'b1; tick(); intr = 1'b0;
    chk("R9 core_rst start", {7'd0, crst}, 8'h01);
    rd(v); chk("R10 int clear", v, 8'h00);
    chk("R10 int run", {6'd0, cpu_en, osc_en}, 8'h03);
    for (int m = 1; m <= 40; m++) begin
      if (m == 10) begin
        sfr_wr(8'h87, 8'hF0);
        rd(v); chk("R10 write during hold", v, 8'h00);
      end else begin
        tick();
      end
      chk("R9 hold length", {7'd0, crst}, (m < 36) ? 8'h01 : 8'h00);
    end
    sfr_wr(8'h87, 8'h80);
    rd(v); chk("R2 write after hold", v, 8'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule